// File: doc/BRIEF.md
# Tape Write Record Assembler

This block gathers 6-bit characters that a data channel delivers for a tape write and assembles them into one record. Each character is translated from the internal character code into BCD on the way in, unless the command word selects binary mode. When the channel ends the record, the buffered characters go to the downstream tape formatter as a single commit. A commit is one of four kinds: a data record, a tape mark, an end-of-medium marker used for erase, or a backspace-record that comes before the marker in reverse erase.

The formatter takes each commit through a valid/ready handshake. It sees the commit kind and the length, and it reads the characters through a random-access read port. The assembler checks the drive's attached and write-lock status before any commit. If either check fails, it raises an error and disconnects instead of committing.

An end-of-record request from the channel is followed by a timed inter-record gap, after which the channel is disconnected. A connect that arrives during the gap cancels the gap. The assembler also tracks the beginning-of-tape and end-of-tape indications for the write path.

Top module: `tape_wr_assembler`

## Requirements
- R1: After reset there is no commit pending, the length is 0, the gap indication is low, the beginning-of-tape flag is 1 and the end-of-tape flag is 0.
- R2: Characters are stored as 6 bits. When command bit 1 (binary) is clear, each character is stored translated: 0 becomes 012, 020 to 037 become 060 to 077, 060 to 077 become 020 to 037, and every other value is stored unchanged. When command bit 1 is set, characters are stored as received. The character at position i can be read at read address i.
- R3: The buffer holds at most DEPTH characters. Characters that arrive when it is full are dropped, and the length stays at DEPTH.
- R4: An end-of-record request gives a one-cycle end-of-record pulse in the next cycle, together with a pending data commit of the buffered length. Once that commit is accepted, the gap indication stays high for GAP_CYCLES cycles, and a one-cycle disconnect pulse follows in the cycle after the gap ends.
- R5: A disconnect with the output qualifier set commits the buffer without a gap and without a disconnect pulse. A disconnect without the qualifier has no effect on the buffer.
- R6: An end of record with an empty buffer makes no commit, but still pulses end-of-record and starts the gap. A disconnect with an empty buffer does nothing.
- R7: When a commit is due and the drive is unattached or write-locked, the block pulses error, end-of-record and disconnect together, makes no commit, and empties the buffer.
- R8: When command bit 2 (erase) is set, a commit is an end-of-medium marker (kind 2). When bit 0 (reverse) is also set, a backspace-record (kind 3) is committed first, followed by the marker.
- R9: A buffer that holds exactly one character equal to 017, under a command whose bits masked by octal 01670 equal octal 00050, commits as a tape mark (kind 1, length 1). Every other non-erase commit is a data record (kind 0).
- R10: Accepting any character clears the beginning-of-tape flag. The end-of-tape flag is set when a data or tape-mark commit is accepted while the past-end-of-tape input is high, provided it was low when the commit began. A connect clears the end-of-tape flag.
- R11: While a commit is pending and not accepted, the valid signal, the kind and the length hold steady. The length is 0 after the final commit of a record is accepted.
- R12: A connect during the gap ends the gap at once, and no disconnect pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conn_i | input | 1 | Connect: latch the command, empty the buffer, cancel a gap |
| cmd_i | input | 12 | Command word (bit 0 reverse, bit 1 binary, bit 2 erase, mark field under mask 01670) |
| chr_valid_i | input | 1 | A character is offered |
| chr_i | input | 6 | Character from the channel |
| eor_i | input | 1 | End-of-record request from the channel |
| disc_i | input | 1 | Disconnect request |
| disc_out_i | input | 1 | Output qualifier of the disconnect |
| attached_i | input | 1 | Drive has a medium attached |
| wlock_i | input | 1 | Drive is write-locked |
| past_eot_i | input | 1 | Drive position is past the end-of-tape threshold |
| commit_valid_o | output | 1 | A commit is pending |
| commit_ready_i | input | 1 | Formatter accepts the commit |
| commit_type_o | output | 2 | 0 data, 1 tape mark, 2 end of medium, 3 backspace record |
| commit_len_o | output | LEN_W = clog2(DEPTH+1) | Characters in the buffer |
| rd_addr_i | input | AW = clog2(DEPTH) | Buffer read address |
| rd_data_o | output | 6 | Buffer character at rd_addr_i |
| eor_pulse_o | output | 1 | End-of-record flag pulse to the channel |
| err_pulse_o | output | 1 | Error flag pulse to the channel |
| disc_pulse_o | output | 1 | Channel disconnect pulse |
| gap_o | output | 1 | Inter-record gap in progress |
| bot_o | output | 1 | Beginning-of-tape flag |
| eot_o | output | 1 | End-of-tape flag |

## Verification
A write pointer that is off by one shows up in the cycle that follows end-of-record, as a wrong commit_len_o, or on the read port as a character at the wrong address. A command field that is captured wrongly shows up in that same cycle as a wrong commit kind, or later as wrong translation on the read port. A gap counter or a sequencing state that is wrong shows up as a gap indication whose length is not GAP_CYCLES. It can also show up as a disconnect pulse that is missing or extra, as a second commit stage in reverse erase, or as a length that is still non-zero after acceptance.

// File: rtl/twr_pkg.sv
package twr_pkg;

    typedef enum logic [1:0] {
        REC_DATA = 2'd0,
        REC_MARK = 2'd1,
        REC_EOM  = 2'd2,
        REC_BACK = 2'd3
    } rec_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COMMIT,
        ST_GAP
    } wr_state_e;

    localparam int CMD_REV   = 0;
    localparam int CMD_BIN   = 1;
    localparam int CMD_ERASE = 2;
    localparam logic [11:0] MARK_MASK = 12'o1670;
    localparam logic [11:0] MARK_CODE = 12'o0050;
    localparam logic [5:0]  MARK_CHAR = 6'o17;

    // internal character code to BCD
    function automatic logic [5:0] to_bcd(input logic [5:0] c);
        logic [5:0] r;
        r = c;
        if (c == 6'o00)
            r = 6'o12;
        else if (c[5:4] == 2'b01)
            r = {2'b11, c[3:0]};
        else if (c[5:4] == 2'b11)
            r = {2'b01, c[3:0]};
        return r;
    endfunction

endpackage

// File: rtl/twr_char_buf.sv
module twr_char_buf #(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [5:0]       wr_data_i,
    input  logic             clr_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [LEN_W-1:0] len_o,
    output logic [5:0]       first_o,
    output logic [5:0]       rd_data_o
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [5:0]       first;
    } buf_st_t;

    buf_st_t q, d;
    logic [5:0] mem_q [DEPTH];
    logic       store;

    assign store = wr_en_i && !clr_i && (q.len < FULL);

    always_comb begin
        d = q;
        if (clr_i) begin
            d.len = '0;
        end else if (store) begin
            d.len = q.len + LEN_W'(1);
            if (q.len == '0)
                d.first = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    always_ff @(posedge clk) begin
        if (store)
            mem_q[q.len[AW-1:0]] <= wr_data_i;
    end

    assign len_o     = q.len;
    assign first_o   = q.first;
    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/twr_gap_timer.sv
module twr_gap_timer #(
    parameter int CYCLES = 16,
    parameter int CW     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cancel_i,
    output logic busy_o,
    output logic done_o
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } gap_st_t;

    gap_st_t q, d;

    assign done_o = q.busy && (q.cnt == '0);

    always_comb begin
        d = q;
        if (cancel_i) begin
            d.busy = 1'b0;
        end else if (start_i) begin
            d.busy = 1'b1;
            d.cnt  = CW'(CYCLES - 1);
        end else if (q.busy) begin
            if (q.cnt == '0)
                d.busy = 1'b0;
            else
                d.cnt = q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign busy_o = q.busy;
endmodule

// File: rtl/tape_wr_assembler.sv
module tape_wr_assembler
    import twr_pkg::*;
#(
    parameter int DEPTH      = 256,
    parameter int GAP_CYCLES = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int GW    = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conn_i,
    input  logic [11:0]      cmd_i,
    input  logic             chr_valid_i,
    input  logic [5:0]       chr_i,
    input  logic             eor_i,
    input  logic             disc_i,
    input  logic             disc_out_i,
    input  logic             attached_i,
    input  logic             wlock_i,
    input  logic             past_eot_i,
    output logic             commit_valid_o,
    input  logic             commit_ready_i,
    output logic [1:0]       commit_type_o,
    output logic [LEN_W-1:0] commit_len_o,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [5:0]       rd_data_o,
    output logic             eor_pulse_o,
    output logic             err_pulse_o,
    output logic             disc_pulse_o,
    output logic             gap_o,
    output logic             bot_o,
    output logic             eot_o
);
    typedef struct packed {
        wr_state_e state;
        rec_kind_e kind;
        logic      gap_after;
        logic      eot_pre;
        logic      rev;
        logic      bin;
        logic      erase;
        logic      mark_sel;
        logic      bot;
        logic      eot;
        logic      eor_p;
        logic      err_p;
        logic      disc_p;
    } ctl_st_t;

    ctl_st_t q, d;

    logic             buf_wr, buf_clr, gap_start, gap_cancel, gap_done;
    logic             do_commit, with_gap, mark_hit;
    logic [LEN_W-1:0] buf_len;
    logic [5:0]       buf_first, wr_code;
    logic             unused_cmd;

    assign unused_cmd = ^{cmd_i[11:10], cmd_i[6]};
    assign wr_code    = q.bin ? chr_i : to_bcd(chr_i);
    assign mark_hit   = q.mark_sel && (buf_len == LEN_W'(1)) && (buf_first == MARK_CHAR);

    twr_char_buf #(.DEPTH(DEPTH), .AW(AW), .LEN_W(LEN_W)) i_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (buf_wr),
        .wr_data_i (wr_code),
        .clr_i     (buf_clr),
        .rd_addr_i (rd_addr_i),
        .len_o     (buf_len),
        .first_o   (buf_first),
        .rd_data_o (rd_data_o)
    );

    twr_gap_timer #(.CYCLES(GAP_CYCLES), .CW(GW)) i_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (gap_start),
        .cancel_i (gap_cancel),
        .busy_o   (gap_o),
        .done_o   (gap_done)
    );

    always_comb begin
        d          = q;
        d.eor_p    = 1'b0;
        d.err_p    = 1'b0;
        d.disc_p   = 1'b0;
        buf_wr     = 1'b0;
        buf_clr    = 1'b0;
        gap_start  = 1'b0;
        gap_cancel = 1'b0;
        do_commit  = 1'b0;
        with_gap   = 1'b0;

        case (q.state)
            ST_IDLE: begin
                if (conn_i) begin
                    d.rev      = cmd_i[CMD_REV];
                    d.bin      = cmd_i[CMD_BIN];
                    d.erase    = cmd_i[CMD_ERASE];
                    d.mark_sel = ((cmd_i & MARK_MASK) == MARK_CODE) && !cmd_i[CMD_ERASE];
                    d.eot      = 1'b0;
                    buf_clr    = 1'b1;
                end else if (eor_i) begin
                    d.eor_p   = 1'b1;
                    do_commit = 1'b1;
                    with_gap  = 1'b1;
                end else if (disc_i && disc_out_i) begin
                    do_commit = 1'b1;
                end else if (chr_valid_i) begin
                    buf_wr = 1'b1;
                    d.bot  = 1'b0;
                end
            end
            ST_COMMIT: begin
                if (commit_ready_i) begin
                    if (q.kind == REC_BACK) begin
                        d.kind = REC_EOM;
                    end else begin
                        buf_clr = 1'b1;
                        if ((q.kind == REC_DATA || q.kind == REC_MARK) &&
                            !q.eot_pre && past_eot_i)
                            d.eot = 1'b1;
                        if (q.gap_after) begin
                            gap_start = 1'b1;
                            d.state   = ST_GAP;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (conn_i) begin
                    gap_cancel = 1'b1;
                    d.state    = ST_IDLE;
                    d.rev      = cmd_i[CMD_REV];
                    d.bin      = cmd_i[CMD_BIN];
                    d.erase    = cmd_i[CMD_ERASE];
                    d.mark_sel = ((cmd_i & MARK_MASK) == MARK_CODE) && !cmd_i[CMD_ERASE];
                    d.eot      = 1'b0;
                    buf_clr    = 1'b1;
                end else if (gap_done) begin
                    d.disc_p = 1'b1;
                    d.state  = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (do_commit) begin
            if (buf_len == '0) begin
                if (with_gap) begin
                    gap_start = 1'b1;
                    d.state   = ST_GAP;
                end
            end else if (!attached_i || wlock_i) begin
                d.err_p  = 1'b1;
                d.eor_p  = 1'b1;
                d.disc_p = 1'b1;
                buf_clr  = 1'b1;
            end else begin
                d.state     = ST_COMMIT;
                d.gap_after = with_gap;
                d.eot_pre   = past_eot_i;
                if (q.erase)
                    d.kind = q.rev ? REC_BACK : REC_EOM;
                else
                    d.kind = mark_hit ? REC_MARK : REC_DATA;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.kind  <= REC_DATA;
            q.bot   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign commit_valid_o = (q.state == ST_COMMIT);
    assign commit_type_o  = q.kind;
    assign commit_len_o   = buf_len;
    assign eor_pulse_o    = q.eor_p;
    assign err_pulse_o    = q.err_p;
    assign disc_pulse_o   = q.disc_p;
    assign bot_o          = q.bot;
    assign eot_o          = q.eot;
endmodule

// File: rtl/twr_checker.sv
module twr_checker #(
    parameter int DEPTH = 256,
    parameter int LEN_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             commit_valid_o,
    input logic             commit_ready_i,
    input logic [1:0]       commit_type_o,
    input logic [LEN_W-1:0] commit_len_o,
    input logic             err_pulse_o,
    input logic             gap_o,
    input logic             bot_o
);
    // R11: pending commit holds its kind and length
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid_o && !commit_ready_i) |=>
            (commit_valid_o && $stable(commit_type_o) && $stable(commit_len_o)));

    // R11: final stage accepted leaves the buffer empty
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid_o && commit_ready_i && commit_type_o != 2'd3) |=>
            (commit_len_o == '0));

    // R8: backspace stage is followed by the end-of-medium stage
    p_back_then_eom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid_o && commit_ready_i && commit_type_o == 2'd3) |=>
            (commit_valid_o && commit_type_o == 2'd2));

    // R3: length never exceeds capacity
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_len_o <= LEN_W'(DEPTH));

    // R7: an error never coincides with a commit
    p_err_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> (!commit_valid_o && commit_len_o == '0));

    // R4: gap and pending commit are exclusive
    p_gap_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gap_o |-> !commit_valid_o);

    // R10: beginning-of-tape flag never returns once cleared
    p_bot_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bot_o |=> !bot_o);
endmodule

bind tape_wr_assembler twr_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W)) i_twr_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .commit_valid_o (commit_valid_o),
    .commit_ready_i (commit_ready_i),
    .commit_type_o  (commit_type_o),
    .commit_len_o   (commit_len_o),
    .err_pulse_o    (err_pulse_o),
    .gap_o          (gap_o),
    .bot_o          (bot_o)
);

// File: tb/test_tape_wr_assembler.sv
`timescale 1ns/1ps
module test_tape_wr_assembler;
    localparam int DEPTH = 256;
    localparam int GAPC  = 16;
    localparam int AW    = 8;
    localparam int LEN_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conn_i = 0, chr_valid_i = 0, eor_i = 0, disc_i = 0, disc_out_i = 0;
    logic attached_i = 1, wlock_i = 0, past_eot_i = 0, commit_ready_i = 0;
    logic [11:0] cmd_i = '0;
    logic [5:0]  chr_i = '0;
    logic [AW-1:0] rd_addr_i = '0;
    logic commit_valid_o, eor_pulse_o, err_pulse_o, disc_pulse_o, gap_o, bot_o, eot_o;
    logic [1:0] commit_type_o;
    logic [LEN_W-1:0] commit_len_o;
    logic [5:0] rd_data_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tape_wr_assembler #(.DEPTH(DEPTH), .GAP_CYCLES(GAPC)) i_tape_wr_assembler (
        .clk(clk), .rst_n(rst_n), .conn_i(conn_i), .cmd_i(cmd_i),
        .chr_valid_i(chr_valid_i), .chr_i(chr_i), .eor_i(eor_i), .disc_i(disc_i),
        .disc_out_i(disc_out_i), .attached_i(attached_i), .wlock_i(wlock_i),
        .past_eot_i(past_eot_i), .commit_valid_o(commit_valid_o),
        .commit_ready_i(commit_ready_i), .commit_type_o(commit_type_o),
        .commit_len_o(commit_len_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .eor_pulse_o(eor_pulse_o), .err_pulse_o(err_pulse_o),
        .disc_pulse_o(disc_pulse_o), .gap_o(gap_o), .bot_o(bot_o), .eot_o(eot_o)
    );

    typedef struct packed {
        logic [11:0] cmd;
        logic [8:0]  n;
        logic [5:0]  base;
        logic [1:0]  kind;
    } vec_t;

    localparam vec_t VECS [0:10] = '{
        '{12'o0002, 9'd5,  6'o00, 2'd0},
        '{12'o0000, 9'd8,  6'o00, 2'd0},
        '{12'o0000, 9'd16, 6'o20, 2'd0},
        '{12'o0000, 9'd16, 6'o60, 2'd0},
        '{12'o0050, 9'd1,  6'o17, 2'd1},
        '{12'o0052, 9'd1,  6'o17, 2'd1},
        '{12'o0050, 9'd2,  6'o17, 2'd0},
        '{12'o0000, 9'd1,  6'o17, 2'd0},
        '{12'o0004, 9'd3,  6'o05, 2'd2},
        '{12'o0005, 9'd3,  6'o05, 2'd3},
        '{12'o1050, 9'd1,  6'o17, 2'd0}
    };

    function automatic logic [5:0] exp_code(input logic [5:0] c, input bit bin);
        if (bin) return c;
        if (c == 6'o00) return 6'o12;
        if (c >= 6'o20 && c <= 6'o37) return c + 6'o40;
        if (c >= 6'o60) return c - 6'o40;
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_conn(input logic [11:0] c);
        @(negedge clk); conn_i = 1; cmd_i = c;
        @(negedge clk); conn_i = 0;
    endtask

    task automatic put(input logic [5:0] c);
        @(negedge clk); chr_valid_i = 1; chr_i = c;
        @(negedge clk); chr_valid_i = 0;
    endtask

    task automatic do_eor();
        @(negedge clk); eor_i = 1;
        @(negedge clk); eor_i = 0;
    endtask

    task automatic do_disc(input bit outq);
        @(negedge clk); disc_i = 1; disc_out_i = outq;
        @(negedge clk); disc_i = 0; disc_out_i = 0;
    endtask

    task automatic accept();
        @(negedge clk); commit_ready_i = 1;
        @(negedge clk); commit_ready_i = 0;
    endtask

    task automatic wait_gap(output int cnt, output bit saw_disc);
        cnt = 0;
        while (gap_o && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        saw_disc = disc_pulse_o;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int gcnt;
        bit sd;
        logic [5:0] c;
        bit bin;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!commit_valid_o, "R1 valid", commit_valid_o, 0);
        chk(commit_len_o == 0, "R1 len", commit_len_o, 0);
        chk(!gap_o, "R1 gap", gap_o, 0);
        chk(bot_o, "R1 bot", bot_o, 1);
        chk(!eot_o, "R1 eot", eot_o, 0);

        // vector walk: R2, R4, R8, R9, R11
        for (int v = 0; v < 11; v++) begin
            do_conn(VECS[v].cmd);
            bin = VECS[v].cmd[1];
            for (int i = 0; i < int'(VECS[v].n); i++) put(VECS[v].base + 6'(i));
            if (v == 0) chk(!bot_o, "R10 bot cleared", bot_o, 0);
            do_eor();
            chk(eor_pulse_o, "R4 eor pulse", eor_pulse_o, 1);
            chk(commit_valid_o, "R4 valid", commit_valid_o, 1);
            chk(commit_type_o == VECS[v].kind, "R9 R8 kind", commit_type_o, VECS[v].kind);
            chk(commit_len_o == LEN_W'(VECS[v].n), "R4 len", commit_len_o, VECS[v].n);
            for (int i = 0; i < int'(VECS[v].n); i++) begin
                rd_addr_i = AW'(i);
                #1;
                c = exp_code(VECS[v].base + 6'(i), bin);
                chk(rd_data_o == c, "R2 data", rd_data_o, c);
            end
            @(negedge clk);
            chk(commit_valid_o && commit_type_o == VECS[v].kind && commit_len_o == LEN_W'(VECS[v].n),
                "R11 hold", commit_type_o, VECS[v].kind);
            if (VECS[v].kind == 2'd3) begin
                accept();
                chk(commit_valid_o && commit_type_o == 2'd2, "R8 eom after back", commit_type_o, 2);
                chk(commit_len_o == LEN_W'(VECS[v].n), "R8 len kept", commit_len_o, VECS[v].n);
            end
            accept();
            chk(!commit_valid_o, "R11 done", commit_valid_o, 0);
            chk(commit_len_o == 0, "R11 len zero", commit_len_o, 0);
            wait_gap(gcnt, sd);
            chk(gcnt == GAPC, "R4 gap length", gcnt, GAPC);
            chk(sd, "R4 disc after gap", sd, 1);
        end

        // R3 overflow
        do_conn(12'o0002);
        for (int i = 0; i < DEPTH + 4; i++) put(6'(i));
        chk(commit_len_o == LEN_W'(DEPTH), "R3 saturate", commit_len_o, DEPTH);
        rd_addr_i = AW'(DEPTH - 1);
        #1;
        chk(rd_data_o == 6'(DEPTH - 1), "R3 last kept", rd_data_o, 6'(DEPTH - 1));

        // R5 disconnect without qualifier has no effect
        do_conn(12'o0002);
        put(6'o11); put(6'o22); put(6'o33);
        do_disc(0);
        chk(!commit_valid_o && commit_len_o == 3, "R5 disc ignored", commit_len_o, 3);
        do_disc(1);
        chk(commit_valid_o && commit_type_o == 0, "R5 disc commit", commit_valid_o, 1);
        accept();
        chk(!gap_o && commit_len_o == 0, "R5 no gap", gap_o, 0);
        @(negedge clk);
        chk(!disc_pulse_o && !gap_o, "R5 no disc pulse", disc_pulse_o, 0);

        // R6 empty buffer
        do_conn(12'o0000);
        do_disc(1);
        chk(!commit_valid_o && !gap_o && !eor_pulse_o, "R6 empty disc", commit_valid_o, 0);
        do_eor();
        chk(eor_pulse_o && !commit_valid_o && gap_o, "R6 empty eor", commit_valid_o, 0);
        wait_gap(gcnt, sd);
        chk(gcnt == GAPC && sd, "R6 gap", gcnt, GAPC);

        // R7 unattached and write-locked
        attached_i = 0;
        do_conn(12'o0000);
        put(6'o01); put(6'o02);
        do_eor();
        chk(err_pulse_o && eor_pulse_o && disc_pulse_o, "R7 unattached flags", err_pulse_o, 1);
        chk(!commit_valid_o && commit_len_o == 0 && !gap_o, "R7 unattached empty", commit_len_o, 0);
        attached_i = 1; wlock_i = 1;
        put(6'o03);
        do_disc(1);
        chk(err_pulse_o && disc_pulse_o && !commit_valid_o, "R7 wlock flags", err_pulse_o, 1);
        chk(commit_len_o == 0, "R7 wlock empty", commit_len_o, 0);
        wlock_i = 0;

        // R10 end-of-tape crossing
        do_conn(12'o0002);
        put(6'o04);
        past_eot_i = 0;
        do_eor();
        past_eot_i = 1;
        accept();
        chk(eot_o, "R10 eot set", eot_o, 1);
        wait_gap(gcnt, sd);
        do_conn(12'o0002);
        chk(!eot_o, "R10 conn clears eot", eot_o, 0);
        put(6'o04);
        do_eor();
        accept();
        chk(!eot_o, "R10 already past", eot_o, 0);

        // R12 connect cancels gap
        chk(gap_o, "R12 in gap", gap_o, 1);
        do_conn(12'o0000);
        chk(!gap_o, "R12 gap ended", gap_o, 0);
        sd = 0;
        for (int i = 0; i < GAPC + 4; i++) begin
            @(negedge clk);
            if (disc_pulse_o) sd = 1;
        end
        chk(!sd, "R12 no disc", sd, 0);
        past_eot_i = 0;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule